// File: doc/BRIEF.md
# Direct-Mapped Address Translation Buffer with Access Rights Check

This block turns a virtual address into a physical address for three kinds of access: data load, data store and instruction fetch. It keeps a direct-mapped table of recently used page table entries, one entry per slot. The slot is chosen by the low bits of the virtual page number, and the full page number is stored as the tag. A lookup that finds a matching tag, in a slot whose stored entry has its leaf bit set, answers on the next cycle. Any other lookup raises a walk request to an external page table walker and holds off new requests until the walker returns an entry. A returned entry with the leaf bit set is written into the slot. One without it ends the access in a fault and leaves the table unchanged.

Each access is then checked against the access-rights field of the entry. The required right depends on the access kind and on whether the requester runs in supervisor mode. A failed check yields an access-fault cause that names the kind of access. A write to the page table base register stores the base with its in-page offset cleared and invalidates every slot at once. The walker itself and the memory data path are outside this block.

Top module: `tlb_xlat`

## Requirements
- R1: After reset `resp_valid` and `walk_req` are low, `req_ready` is high, `ptbr` is zero and every slot is invalid, so the first access to any page requests a walk.
- R2: The slot is the virtual page number (address >> 12) modulo ENTRIES and the tag is the whole page number, so two pages whose numbers differ by a multiple of ENTRIES evict each other.
- R3: An access hits when the slot's stored entry has bit 1 (leaf) set and its tag equals the page number. A hit raises `resp_valid` on the cycle after acceptance and raises no walk request.
- R4: On a miss, `walk_req` rises the cycle after acceptance with `walk_vaddr` equal to the request address. `req_ready` stays low until the cycle in which `walk_rsp_valid` is sampled high, and `resp_valid` follows one cycle later.
- R5: A returned entry is written into the slot, with its tag, only if its bit 1 is set. Otherwise the access faults and the table is left as it was, so the old contents of the slot still hit and the same page walks again.
- R6: `req_kind` is encoded as 2'b00 load, 2'b01 store, 2'b10 fetch and 2'b11 load. In user mode the required entry bit is 6 for a load, 5 for a store and 4 for a fetch. In supervisor mode (`req_super` high) it is 9, 8 and 7 respectively.
- R7: An access with a valid entry faults exactly when the required bit is clear. Entry bits outside 9..4 (other than the leaf bit on a refill) have no effect on the outcome.
- R8: `resp_cause` is 0 when there is no fault. On a fault it is 1 for a fetch, 2 for a load (kinds 00 and 11) and 3 for a store. `resp_fault` is high exactly when `resp_cause` is non-zero.
- R9: Without a fault, `resp_paddr` holds entry bits 63..12 above address bits 11..0. With a fault, `resp_paddr` is zero.
- R10: A pulse on `ptbr_wr` sets `ptbr` on the next cycle to `ptbr_wdata` with bits 11..0 cleared, and invalidates all slots, so every later access walks until refilled. In the same cycle, the flush takes precedence over a refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | High when a request can be accepted (no walk pending) |
| req_addr | input | 64 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 load |
| req_super | input | 1 | Requester is in supervisor mode |
| resp_valid | output | 1 | One-cycle pulse: result of the accepted request |
| resp_fault | output | 1 | Access fault flag |
| resp_cause | output | 2 | 0 none, 1 fetch fault, 2 load fault, 3 store fault |
| resp_paddr | output | 64 | Physical address, zero on fault |
| walk_req | output | 1 | Walk requested, held until the response |
| walk_vaddr | output | 64 | Virtual address to walk |
| walk_rsp_valid | input | 1 | Walker entry available |
| walk_rsp_pte | input | 64 | Page table entry returned by the walker |
| ptbr_wr | input | 1 | Write strobe for the page table base |
| ptbr_wdata | input | 64 | New page table base |
| ptbr | output | 64 | Current page-aligned page table base |

## Verification
On every cycle, the assertions check the handshake timing: a hit answers on the next cycle, and a miss raises a walk for the accepted address. They also check that a walker response ends the stall, that only leaf entries are written, that a flush leaves nothing hitting, that a refill is visible at once, and that the fault flag, the cause and a zeroed address agree. The permission table itself, the cause chosen per kind, address composition, eviction between colliding pages, the unchanged table after a non-leaf walk, and base alignment can only be shown by the bench. It sweeps every combination of the six rights bits with all four kind codes and both modes, and compares each result with values it computes arithmetically.

// File: rtl/tlb_pkg.sv
// Package: shared encodings for the translation buffer.
// Holds the access-kind and fault-cause codes, the controller states and
// the bit positions inside a page table entry that the block relies on.
package tlb_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD     = 2'b00,
        ACC_STORE    = 2'b01,
        ACC_FETCH    = 2'b10,
        ACC_LOAD_ALT = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'd0,
        CAUSE_FETCH_AF = 2'd1,
        CAUSE_LOAD_AF  = 2'd2,
        CAUSE_STORE_AF = 2'd3
    } cause_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } ctrl_state_e;

    localparam int LEAF_POS      = 1;
    localparam int RIGHTS_LO_POS = 4;
    localparam int RIGHTS_HI_POS = 9;
    localparam int USR_EXEC_POS  = 4;
    localparam int USR_WRITE_POS = 5;
    localparam int USR_READ_POS  = 6;
    localparam int SUP_SHIFT     = 3;

endpackage

// File: rtl/tlb_store.sv
// Module: tlb_store
// Direct-mapped table of cached page table entries with full-page tags.
// Assumes ENTRIES is a power of two, at least 2. A slot is valid while the
// leaf bit of its stored entry is set; a flush clears that bit in every
// slot and takes precedence over a write in the same cycle.
module tlb_store
    import tlb_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int PAGE_SHIFT = 12,
    parameter int ENTRIES    = 256
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-PAGE_SHIFT-1:0] lk_vpn,
    output logic                        lk_hit,
    output logic [ADDR_W-1:0]           lk_pte,
    input  logic                        wr_en,
    input  logic [ADDR_W-PAGE_SHIFT-1:0] wr_vpn,
    input  logic [ADDR_W-1:0]           wr_pte,
    input  logic                        flush
);

    localparam int VPN_W = ADDR_W - PAGE_SHIFT;
    localparam int IDX_W = $clog2(ENTRIES);

    logic [IDX_W-1:0]  lk_idx;
    logic [IDX_W-1:0]  wr_idx;
    logic [ADDR_W-1:0] pte_vec [ENTRIES];
    logic [VPN_W-1:0]  tag_vec [ENTRIES];

    assign lk_idx = lk_vpn[IDX_W-1:0];
    assign wr_idx = wr_vpn[IDX_W-1:0];

    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
            logic [ADDR_W-1:0] pte_r;
            logic [VPN_W-1:0]  tag_r;
            logic              sel;

            assign sel = wr_en && (wr_idx == IDX_W'(e));

            // Entry storage: cleared on reset, leaf bit dropped on flush, loaded on refill.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pte_r <= '0;
                end else if (flush) begin
                    pte_r[LEAF_POS] <= 1'b0;
                end else if (sel) begin
                    pte_r <= wr_pte;
                end
            end

            // Tag storage: takes the full page number on a refill that is not overridden.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tag_r <= '0;
                end else if (sel && !flush) begin
                    tag_r <= wr_vpn;
                end
            end

            assign pte_vec[e] = pte_r;
            assign tag_vec[e] = tag_r;
        end
    endgenerate

    // Lookup: read the indexed slot and compare validity and tag.
    always_comb begin
        lk_pte = pte_vec[lk_idx];
        lk_hit = lk_pte[LEAF_POS] && (tag_vec[lk_idx] == lk_vpn);
    end

    // R10: after a flush no lookup can hit.
    assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit);

    // R5: only entries with the leaf bit set are ever written.
    assert_refill_leaf_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_pte[LEAF_POS]);

    // R3: a refilled page hits if it is looked up in the next cycle.
    assert_refill_visible_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |=> ((lk_vpn != $past(wr_vpn)) || lk_hit));

endmodule

// File: rtl/tlb_perm.sv
// Module: tlb_perm
// Combinational rights check and physical address composition.
// Assumes the entry bits 9..4 carry the rights: user exec/write/read at
// 4/5/6, supervisor rights three positions higher. entry_ok low means the
// entry is not a usable leaf and the access faults regardless of rights.
module tlb_perm
    import tlb_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int PAGE_SHIFT = 12
) (
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [ADDR_W-1:0] pte,
    input  logic [1:0]        kind,
    input  logic              super_mode,
    input  logic              entry_ok,
    output logic              fault,
    output logic [1:0]        cause,
    output logic [ADDR_W-1:0] paddr
);

    localparam logic [ADDR_W-1:0] RIGHTS_MASK =
        ((ADDR_W'(1) << (RIGHTS_HI_POS + 1)) - ADDR_W'(1)) & ~((ADDR_W'(1) << RIGHTS_LO_POS) - ADDR_W'(1));

    acc_kind_e         kind_e;
    logic [ADDR_W-1:0] user_need;
    logic [ADDR_W-1:0] need;
    logic              granted;

    assign kind_e = acc_kind_e'(kind);

    // Required right: one user bit per kind, moved up for supervisor mode.
    always_comb begin
        unique case (kind_e)
            ACC_STORE: user_need = ADDR_W'(1) << USR_WRITE_POS;
            ACC_FETCH: user_need = ADDR_W'(1) << USR_EXEC_POS;
            default:   user_need = ADDR_W'(1) << USR_READ_POS;
        endcase
        need    = super_mode ? (user_need << SUP_SHIFT) : user_need;
        granted = |(need & pte & RIGHTS_MASK);
    end

    // Outcome: fault flag, cause by kind, and the composed physical address.
    always_comb begin
        fault = !entry_ok || !granted;
        if (!fault) begin
            cause = CAUSE_NONE;
        end else begin
            unique case (kind_e)
                ACC_STORE: cause = CAUSE_STORE_AF;
                ACC_FETCH: cause = CAUSE_FETCH_AF;
                default:   cause = CAUSE_LOAD_AF;
            endcase
        end
        paddr = fault ? '0 : {pte[ADDR_W-1:PAGE_SHIFT], vaddr[PAGE_SHIFT-1:0]};
    end

endmodule

// File: rtl/tlb_ctrl.sv
// Module: tlb_ctrl
// Request sequencing: looks up the table on acceptance, answers a hit on
// the next cycle, or holds the request and waits for the external walker.
// Assumes the walker answers only while walk_req is high. Results are
// registered and pulse resp_valid for one cycle.
module tlb_ctrl
    import tlb_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int PAGE_SHIFT = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [1:0]                   req_kind,
    input  logic                         req_super,
    output logic [ADDR_W-PAGE_SHIFT-1:0] lk_vpn,
    input  logic                         lk_hit,
    input  logic [ADDR_W-1:0]            lk_pte,
    output logic                         wr_en,
    output logic [ADDR_W-PAGE_SHIFT-1:0] wr_vpn,
    output logic [ADDR_W-1:0]            wr_pte,
    output logic [ADDR_W-1:0]            chk_vaddr,
    output logic [ADDR_W-1:0]            chk_pte,
    output logic [1:0]                   chk_kind,
    output logic                         chk_super,
    output logic                         chk_ok,
    input  logic                         chk_fault,
    input  logic [1:0]                   chk_cause,
    input  logic [ADDR_W-1:0]            chk_paddr,
    output logic                         walk_req,
    output logic [ADDR_W-1:0]            walk_vaddr,
    input  logic                         walk_rsp_valid,
    input  logic [ADDR_W-1:0]            walk_rsp_pte,
    output logic                         resp_valid,
    output logic                         resp_fault,
    output logic [1:0]                   resp_cause,
    output logic [ADDR_W-1:0]            resp_paddr
);

    ctrl_state_e       state_q;
    logic [ADDR_W-1:0] held_addr_q;
    logic [1:0]        held_kind_q;
    logic              held_super_q;
    logic              accept;
    logic              done_hit;
    logic              done_walk;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign done_hit  = accept && lk_hit;
    assign done_walk = (state_q == ST_WALK) && walk_rsp_valid;
    assign lk_vpn    = req_addr[ADDR_W-1:PAGE_SHIFT];

    assign walk_req   = (state_q == ST_WALK);
    assign walk_vaddr = held_addr_q;

    assign wr_en  = done_walk && walk_rsp_pte[LEAF_POS];
    assign wr_vpn = held_addr_q[ADDR_W-1:PAGE_SHIFT];
    assign wr_pte = walk_rsp_pte;

    // Check operands: the live request on a hit, the held request after a walk.
    always_comb begin
        if (state_q == ST_WALK) begin
            chk_vaddr = held_addr_q;
            chk_pte   = walk_rsp_pte;
            chk_kind  = held_kind_q;
            chk_super = held_super_q;
            chk_ok    = walk_rsp_pte[LEAF_POS];
        end else begin
            chk_vaddr = req_addr;
            chk_pte   = lk_pte;
            chk_kind  = req_kind;
            chk_super = req_super;
            chk_ok    = 1'b1;
        end
    end

    // State: enter the walk wait on a missed acceptance, leave on the walker answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (accept && !lk_hit) begin
            state_q <= ST_WALK;
        end else if (done_walk) begin
            state_q <= ST_IDLE;
        end
    end

    // Held request: captured on every acceptance for use during a walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_addr_q  <= '0;
            held_kind_q  <= '0;
            held_super_q <= 1'b0;
        end else if (accept) begin
            held_addr_q  <= req_addr;
            held_kind_q  <= req_kind;
            held_super_q <= req_super;
        end
    end

    // Response register: one-cycle result pulse with fault, cause and address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_fault <= 1'b0;
            resp_cause <= '0;
            resp_paddr <= '0;
        end else begin
            resp_valid <= done_hit || done_walk;
            if (done_hit || done_walk) begin
                resp_fault <= chk_fault;
                resp_cause <= chk_cause;
                resp_paddr <= chk_paddr;
            end
        end
    end

    // R3: an accepted hit answers on the next cycle without a walk.
    assert_hit_next_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && lk_hit) |=> (resp_valid && !walk_req));

    // R4: an accepted miss raises a walk for the accepted address.
    assert_miss_walks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !lk_hit) |=> (walk_req && !req_ready && (walk_vaddr == $past(req_addr))));

    // R4: the walker answer releases the stall and produces the response.
    assert_walk_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && walk_rsp_valid) |=> (resp_valid && req_ready && !walk_req));

    // R8: fault flag agrees with a non-zero cause.
    assert_cause_agrees_R8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_fault == (resp_cause != 2'd0)));

    // R9: a faulting response carries no address.
    assert_fault_no_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |-> (resp_paddr == '0));

endmodule

// File: rtl/tlb_xlat.sv
// Module: tlb_xlat (top)
// Virtual-to-physical translation with a direct-mapped entry table, an
// external walker port and a rights check per access kind and mode.
// Assumes ADDR_W > PAGE_SHIFT > RIGHTS_HI_POS and ENTRIES a power of two.
// A base register write page-aligns the base and invalidates the table.
module tlb_xlat
    import tlb_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int PAGE_SHIFT = 12,
    parameter int ENTRIES    = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_kind,
    input  logic              req_super,
    output logic              resp_valid,
    output logic              resp_fault,
    output logic [1:0]        resp_cause,
    output logic [ADDR_W-1:0] resp_paddr,
    output logic              walk_req,
    output logic [ADDR_W-1:0] walk_vaddr,
    input  logic              walk_rsp_valid,
    input  logic [ADDR_W-1:0] walk_rsp_pte,
    input  logic              ptbr_wr,
    input  logic [ADDR_W-1:0] ptbr_wdata,
    output logic [ADDR_W-1:0] ptbr
);

    localparam int VPN_W = ADDR_W - PAGE_SHIFT;

    logic [VPN_W-1:0]  lk_vpn;
    logic              lk_hit;
    logic [ADDR_W-1:0] lk_pte;
    logic              wr_en;
    logic [VPN_W-1:0]  wr_vpn;
    logic [ADDR_W-1:0] wr_pte;
    logic [ADDR_W-1:0] chk_vaddr;
    logic [ADDR_W-1:0] chk_pte;
    logic [1:0]        chk_kind;
    logic              chk_super;
    logic              chk_ok;
    logic              chk_fault;
    logic [1:0]        chk_cause;
    logic [ADDR_W-1:0] chk_paddr;
    logic [ADDR_W-1:0] ptbr_q;

    // Base register: keeps only the page-number part of the written value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptbr_q <= '0;
        end else if (ptbr_wr) begin
            ptbr_q <= {ptbr_wdata[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
        end
    end

    assign ptbr = ptbr_q;

    tlb_store #(
        .ADDR_W    (ADDR_W),
        .PAGE_SHIFT(PAGE_SHIFT),
        .ENTRIES   (ENTRIES)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .lk_vpn(lk_vpn),
        .lk_hit(lk_hit),
        .lk_pte(lk_pte),
        .wr_en (wr_en),
        .wr_vpn(wr_vpn),
        .wr_pte(wr_pte),
        .flush (ptbr_wr)
    );

    tlb_ctrl #(
        .ADDR_W    (ADDR_W),
        .PAGE_SHIFT(PAGE_SHIFT)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .req_kind      (req_kind),
        .req_super     (req_super),
        .lk_vpn        (lk_vpn),
        .lk_hit        (lk_hit),
        .lk_pte        (lk_pte),
        .wr_en         (wr_en),
        .wr_vpn        (wr_vpn),
        .wr_pte        (wr_pte),
        .chk_vaddr     (chk_vaddr),
        .chk_pte       (chk_pte),
        .chk_kind      (chk_kind),
        .chk_super     (chk_super),
        .chk_ok        (chk_ok),
        .chk_fault     (chk_fault),
        .chk_cause     (chk_cause),
        .chk_paddr     (chk_paddr),
        .walk_req      (walk_req),
        .walk_vaddr    (walk_vaddr),
        .walk_rsp_valid(walk_rsp_valid),
        .walk_rsp_pte  (walk_rsp_pte),
        .resp_valid    (resp_valid),
        .resp_fault    (resp_fault),
        .resp_cause    (resp_cause),
        .resp_paddr    (resp_paddr)
    );

    tlb_perm #(
        .ADDR_W    (ADDR_W),
        .PAGE_SHIFT(PAGE_SHIFT)
    ) u_perm (
        .vaddr     (chk_vaddr),
        .pte       (chk_pte),
        .kind      (chk_kind),
        .super_mode(chk_super),
        .entry_ok  (chk_ok),
        .fault     (chk_fault),
        .cause     (chk_cause),
        .paddr     (chk_paddr)
    );

    // R10: the base register is page aligned and follows the written page number.
    assert_base_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ptbr_wr |=> ((ptbr[PAGE_SHIFT-1:0] == '0) &&
                     (ptbr[ADDR_W-1:PAGE_SHIFT] == $past(ptbr_wdata[ADDR_W-1:PAGE_SHIFT]))));

endmodule

// File: tb/tlb_xlat_test.sv
// Bench for tlb_xlat with an 8-slot table. A bench-side walker builds
// entries from a chosen rights field and leaf flag; a shadow table predicts
// hits, and every result is computed arithmetically from the requirements.
module tlb_xlat_test;

    localparam int AW = 64;
    localparam int NE = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_kind = '0;
    logic          req_super = 1'b0;
    logic          resp_valid;
    logic          resp_fault;
    logic [1:0]    resp_cause;
    logic [AW-1:0] resp_paddr;
    logic          walk_req;
    logic [AW-1:0] walk_vaddr;
    logic          walk_rsp_valid = 1'b0;
    logic [AW-1:0] walk_rsp_pte = '0;
    logic          ptbr_wr = 1'b0;
    logic [AW-1:0] ptbr_wdata = '0;
    logic [AW-1:0] ptbr;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    logic [5:0]    g_rights = '0;
    logic          g_leaf = 1'b1;
    bit            sh_v   [NE];
    logic [51:0]   sh_tag [NE];
    logic [AW-1:0] sh_pte [NE];

    always #5 clk = ~clk;

    tlb_xlat #(.ADDR_W(AW), .PAGE_SHIFT(12), .ENTRIES(NE)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_kind(req_kind), .req_super(req_super),
        .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_cause(resp_cause),
        .resp_paddr(resp_paddr),
        .walk_req(walk_req), .walk_vaddr(walk_vaddr),
        .walk_rsp_valid(walk_rsp_valid), .walk_rsp_pte(walk_rsp_pte),
        .ptbr_wr(ptbr_wr), .ptbr_wdata(ptbr_wdata), .ptbr(ptbr)
    );

    task automatic check(input bit ok, input string rq, input logic [AW-1:0] act,
                         input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Walker entry: page number, stray bits set outside the rights field.
    function automatic logic [AW-1:0] make_pte(input logic [51:0] vpn);
        logic [51:0] ppn;
        ppn = vpn ^ 52'hA_5A5A_C3C3;
        return {ppn, 2'b11, g_rights, 2'b11, g_leaf, 1'b1};
    endfunction

    task automatic access(input logic [51:0] vpn, input logic [11:0] off,
                          input logic [1:0] k, input logic s, input string rq);
        int            idx;
        bit            exp_hit;
        bit            exp_fault;
        int            bitpos;
        logic [1:0]    exp_cause;
        logic [AW-1:0] pte;
        logic [AW-1:0] a;
        logic [AW-1:0] exp_pa;
        a = {vpn, off};
        idx = int'(vpn % NE);
        exp_hit = sh_v[idx] && (sh_tag[idx] == vpn);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_kind = k; req_super = s;
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (exp_hit) begin
            check(resp_valid && !walk_req, {rq, " hit answers next cycle (R3)"},
                  {62'b0, resp_valid, walk_req}, 64'd2);
            pte = sh_pte[idx];
        end else begin
            check(walk_req && !req_ready && !resp_valid && walk_vaddr == a,
                  {rq, " miss walks (R4)"}, walk_vaddr, a);
            pte = make_pte(vpn);
            repeat (2) @(posedge clk);
            #1;
            check(walk_req && !req_ready, "stall held during walk (R4)",
                  {62'b0, walk_req, req_ready}, 64'd2);
            walk_rsp_valid = 1'b1; walk_rsp_pte = pte;
            @(posedge clk); #1;
            walk_rsp_valid = 1'b0;
            check(resp_valid && req_ready && !walk_req, "response after walk (R4)",
                  {62'b0, resp_valid, req_ready}, 64'd3);
            if (pte[1]) begin
                sh_v[idx] = 1'b1; sh_tag[idx] = vpn; sh_pte[idx] = pte;
            end
        end
        bitpos = (k == 2'b01) ? 5 : (k == 2'b10) ? 4 : 6;
        if (s) bitpos = bitpos + 3;
        exp_fault = !pte[1] || !pte[bitpos];
        exp_cause = !exp_fault ? 2'd0 : (k == 2'b01) ? 2'd3 : (k == 2'b10) ? 2'd1 : 2'd2;
        exp_pa = exp_fault ? '0 : {pte[63:12], off};
        check(resp_fault == exp_fault, "fault per rights bit (R6 R7)",
              {63'b0, resp_fault}, {63'b0, exp_fault});
        check(resp_cause == exp_cause, "cause per kind (R8)",
              {62'b0, resp_cause}, {62'b0, exp_cause});
        check(resp_paddr == exp_pa, "physical address (R9)", resp_paddr, exp_pa);
        @(posedge clk); #1;
        check(!resp_valid, "response is one pulse (R3)", {63'b0, resp_valid}, 64'd0);
    endtask

    task automatic write_base(input logic [AW-1:0] v);
        @(negedge clk);
        ptbr_wr = 1'b1; ptbr_wdata = v;
        @(posedge clk); #1;
        ptbr_wr = 1'b0;
        for (int i = 0; i < NE; i++) sh_v[i] = 1'b0;
        check(ptbr == {v[63:12], 12'h000}, "base page aligned (R10)", ptbr,
              {v[63:12], 12'h000});
    endtask

    initial begin
        for (int i = 0; i < NE; i++) begin
            sh_v[i] = 1'b0; sh_tag[i] = '0; sh_pte[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: reset state
        check(!resp_valid && !walk_req && req_ready, "reset handshake (R1)",
              {61'b0, resp_valid, walk_req, req_ready}, 64'd1);
        check(ptbr == '0, "reset base (R1)", ptbr, 64'd0);
        access(52'h0_0000_0042, 12'h123, 2'b00, 1'b0, "first access after reset R1");

        // Sweep all rights patterns with every kind code and both modes (R6 R7 R11-style kind 11).
        for (int p = 0; p < 64; p++) begin
            g_rights = 6'(p);
            g_leaf = 1'b1;
            for (int k = 0; k < 4; k++) begin
                for (int s = 0; s < 2; s++) begin
                    access(52'h1_2345 + 52'(p * 5), 12'(p * 37 + k), 2'(k), s[0], "sweep");
                end
            end
        end

        // R2: colliding pages evict each other.
        g_rights = 6'h3F;
        access(52'h777, 12'h010, 2'b00, 1'b0, "R2 fill A");
        access(52'h777 + 52'(NE), 12'h020, 2'b01, 1'b0, "R2 fill B same slot");
        access(52'h777, 12'h030, 2'b10, 1'b1, "R2 A evicted");
        access(52'h777, 12'h040, 2'b00, 1'b1, "R2 A hits again");

        // R5: non-leaf entry faults and leaves the table untouched.
        g_leaf = 1'b0;
        access(52'h777 + 52'(2 * NE), 12'h050, 2'b01, 1'b0, "R5 non-leaf store");
        access(52'h777 + 52'(2 * NE), 12'h060, 2'b10, 1'b0, "R5 non-leaf fetch");
        access(52'h777 + 52'(2 * NE), 12'h070, 2'b11, 1'b1, "R5 non-leaf load");
        g_leaf = 1'b1;
        access(52'h777, 12'h080, 2'b00, 1'b0, "R5 old slot still hits");
        access(52'h777 + 52'(2 * NE), 12'h090, 2'b00, 1'b0, "R5 walks again");

        // R10: base write aligns and invalidates.
        write_base(64'hFFFF_FFFF_FFFF_FABC);
        access(52'h777 + 52'(2 * NE), 12'h0A0, 2'b00, 1'b0, "R10 flushed");
        write_base(64'h0000_1234_5678_9FFF);
        access(52'h777 + 52'(2 * NE), 12'hFFF, 2'b10, 1'b1, "R10 flushed again");

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule